// File: doc/BRIEF.md
# Three-Form Instruction Decoder

This block takes one 16-bit instruction word and, with no clock and no state, works out which of three encoding forms it uses. It pulls out the opcode, the register indices and the short immediate that form carries, and it reports the total length of the instruction in bytes. The fetch stage uses that length to decide whether 2 or 4 more bytes of extension follow the word.

The two top bits act as a prefix code. A clear bit 15 gives the register form. Set-then-clear gives the short-immediate form. Both set gives the branch form. The decoder also marks three things for the execute stage: undefined encodings, the breakpoint trap opcode, and instructions that change control flow. It does no execution, does not fetch extension bytes and holds no registers.

Top module: `instr_form_decoder`

## Requirements
- R1: `form_o` is 1 when bit 15 is 0, 2 when bits 15:14 are 10, and 3 when bits 15:14 are 11.
- R2: In form 1, `opcode_o` is bits 15:8, `reg_a_o` is bits 7:4 and `reg_b_o` is bits 3:0, and `imm_o` is 0.
- R3: In form 2, `opcode_o` is bits 13:12 zero-extended, `reg_a_o` is bits 11:8, `reg_b_o` is 0 and `imm_o` is bits 7:0 unsigned. All four form-2 opcodes are legal.
- R4: In form 3, `opcode_o` is bits 13:10 zero-extended, and `reg_a_o`, `reg_b_o` and `imm_o` are 0.
- R5: Legal form-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24 and 0x30 give `len_o` = 6, for a 32-bit extension.
- R6: Form-1 opcodes 0x0C, 0x0D, 0x36, 0x37, 0x38 and 0x39 give `len_o` = 4, for a 16-bit signed offset extension.
- R7: Every other legal instruction gives `len_o` = 2. This covers the remaining form-1 opcodes and all of forms 2 and 3. `len_o` only ever takes the values 2, 4 or 6.
- R8: A form-1 opcode of 0x00, 0x16, 0x17, 0x18, or anything above 0x39, sets `illegal_o`.
- R9: A form-3 opcode above 9 sets `illegal_o`, and form-3 opcodes 0 to 9 are legal.
- R10: When `illegal_o` is 1, `len_o` is 2.
- R11: `trap_o` is 1 only for form-1 opcode 0x35, and that word is not illegal.
- R12: `flow_o` is 1 for every form-3 word and for form-1 opcodes 0x03, 0x04, 0x19, 0x1A, 0x25 and 0x30. It is 0 for all other words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word |
| form_o | output | 2 | Encoding form: 1, 2 or 3 |
| opcode_o | output | 8 | Opcode field, zero-extended |
| reg_a_o | output | 4 | First register index |
| reg_b_o | output | 4 | Second register index |
| imm_o | output | 8 | Unsigned 8-bit immediate (form 2 only) |
| len_o | output | 3 | Total instruction length in bytes |
| illegal_o | output | 1 | Undefined encoding |
| trap_o | output | 1 | Breakpoint trap opcode |
| flow_o | output | 1 | Control-flow instruction |

## Verification
The embedded assertions check properties that must hold for every word on every evaluation:
- an illegal word always has length 2;
- the length is always one of the three legal values;
- a trap never comes with the illegal flag;
- every branch-form word is marked as control flow;
- the fields that a form does not use are zero.

The assertions cannot show that each individual opcode lands in the right length class, legality class or control-flow class. Only the bench can show that. It walks every one of the 65,536 words, plus directed corner words, against its own independent model.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int WORD_W   = 16;
  localparam int OPC_W    = 8;
  localparam int RIDX_W   = 4;
  localparam int IMM_W    = 8;
  localparam int LEN_W    = 3;
  localparam int BR_OPC_W = 4;
  localparam int BR_LAST  = 9;

  localparam logic [1:0] FORM_REG    = 2'd1;
  localparam logic [1:0] FORM_SHORT  = 2'd2;
  localparam logic [1:0] FORM_BRANCH = 2'd3;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_HALF = 2'd1,
    EXT_WORD = 2'd2
  } ext_e;

  // Size of the extension that follows a form-1 word
  function automatic ext_e f1_ext(input logic [OPC_W-1:0] op);
    ext_e r;
    r = EXT_NONE;
    if (op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h1A, 8'h1B, 8'h1D,
                   8'h1F, 8'h20, 8'h22, 8'h24, 8'h30})
      r = EXT_WORD;
    else if (op inside {8'h0C, 8'h0D, [8'h36:8'h39]})
      r = EXT_HALF;
    return r;
  endfunction

  function automatic logic f1_illegal(input logic [OPC_W-1:0] op);
    return (op == 8'h00) || (op inside {[8'h16:8'h18]}) || (op > 8'h39);
  endfunction

  function automatic logic f1_trap(input logic [OPC_W-1:0] op);
    return op == 8'h35;
  endfunction

  function automatic logic f1_flow(input logic [OPC_W-1:0] op);
    return op inside {8'h03, 8'h04, 8'h19, 8'h1A, 8'h25, 8'h30};
  endfunction

  function automatic logic br_illegal(input logic [BR_OPC_W-1:0] op);
    return int'(op) > BR_LAST;
  endfunction

  // Total byte count of an instruction for a given extension class
  function automatic logic [LEN_W-1:0] len_bytes(input ext_e e);
    logic [LEN_W-1:0] l;
    case (e)
      EXT_HALF: l = 3'd4;
      EXT_WORD: l = 3'd6;
      default:  l = 3'd2;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/dec_field_split.sv
module dec_field_split
  import dec_pkg::*;
#(
  parameter int P_WORD_W = WORD_W,
  parameter int P_OPC_W  = OPC_W,
  parameter int P_RIDX_W = RIDX_W,
  parameter int P_IMM_W  = IMM_W
) (
  input  logic [P_WORD_W-1:0] word_i,
  output logic [1:0]          form_o,
  output logic [P_OPC_W-1:0]  opc_o,
  output logic [P_RIDX_W-1:0] ra_o,
  output logic [P_RIDX_W-1:0] rb_o,
  output logic [P_IMM_W-1:0]  imm_o
);
  localparam int TOP   = P_WORD_W - 1;
  localparam int SUB   = P_WORD_W - 2;
  localparam int F2_OW = 2;
  localparam int F3_OW = BR_OPC_W;
  localparam int F2_OL = SUB - F2_OW;
  localparam int F3_OL = SUB - F3_OW;

  logic sel_short, sel_branch;
  assign sel_branch = word_i[TOP] & word_i[SUB];
  assign sel_short  = word_i[TOP] & ~word_i[SUB];

  always_comb begin
    form_o = FORM_REG;
    opc_o  = word_i[TOP -: P_OPC_W];
    ra_o   = word_i[2*P_RIDX_W-1 -: P_RIDX_W];
    rb_o   = word_i[P_RIDX_W-1:0];
    imm_o  = '0;
    if (sel_short) begin
      form_o = FORM_SHORT;
      opc_o  = P_OPC_W'(word_i[SUB-1 -: F2_OW]);
      ra_o   = word_i[F2_OL-1 -: P_RIDX_W];
      rb_o   = '0;
      imm_o  = word_i[P_IMM_W-1:0];
    end else if (sel_branch) begin
      form_o = FORM_BRANCH;
      opc_o  = P_OPC_W'(word_i[SUB-1 -: F3_OW]);
      ra_o   = '0;
      rb_o   = '0;
    end
  end

  logic unused_f3;
  assign unused_f3 = ^F3_OL;

  always_comb begin
    if (form_o == FORM_SHORT)
      AST_SHORT_FIELDS: assert (rb_o == '0 && opc_o < 4) else $error("short form fields"); // R3
    if (form_o == FORM_BRANCH)
      AST_BRANCH_FIELDS: assert (ra_o == '0 && rb_o == '0 && imm_o == '0 && opc_o < 16) else $error("branch fields"); // R4
  end
endmodule

// File: rtl/dec_op_table.sv
module dec_op_table
  import dec_pkg::*;
#(
  parameter int P_OPC_W = OPC_W
) (
  input  logic [P_OPC_W-1:0] opc_i,
  output ext_e               ext_o,
  output logic               ill_o,
  output logic               trap_o,
  output logic               flow_o
);
  localparam int TABLE_N = 1 << P_OPC_W;

  logic [TABLE_N-1:0] ill_vec, trap_vec, flow_vec;
  ext_e               ext_vec [TABLE_N];

  for (genvar g = 0; g < TABLE_N; g++) begin : g_row
    assign ill_vec[g]  = f1_illegal(OPC_W'(g));
    assign trap_vec[g] = f1_trap(OPC_W'(g));
    assign flow_vec[g] = f1_flow(OPC_W'(g));
    assign ext_vec[g]  = f1_ext(OPC_W'(g));
  end

  assign ill_o  = ill_vec[opc_i];
  assign trap_o = trap_vec[opc_i];
  assign flow_o = flow_vec[opc_i];
  assign ext_o  = ext_vec[opc_i];

  always_comb begin
    AST_TRAP_LEGAL: assert (!(trap_o && ill_o)) else $error("trap marked illegal"); // R11
    AST_ILL_NO_EXT: assert (!(ill_o && ext_o != EXT_NONE)) else $error("illegal with extension"); // R10
  end
endmodule

// File: rtl/dec_branch_check.sv
module dec_branch_check
  import dec_pkg::*;
#(
  parameter int P_BR_W = BR_OPC_W
) (
  input  logic [P_BR_W-1:0] br_op_i,
  output logic              ill_o
);
  localparam int BR_N = 1 << P_BR_W;

  logic [BR_N-1:0] ill_vec;
  for (genvar g = 0; g < BR_N; g++) begin : g_br
    assign ill_vec[g] = br_illegal(BR_OPC_W'(g));
  end
  assign ill_o = ill_vec[br_op_i];

  always_comb begin
    if (br_op_i == '0)
      AST_BR_ZERO_OK: assert (!ill_o) else $error("branch opcode 0 illegal"); // R9
  end
endmodule

// File: rtl/instr_form_decoder.sv
module instr_form_decoder
  import dec_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output logic [1:0]        form_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [RIDX_W-1:0] reg_a_o,
  output logic [RIDX_W-1:0] reg_b_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              illegal_o,
  output logic              trap_o,
  output logic              flow_o
);
  // Named internal events
  ext_e f1_ext_w;
  logic f1_ill_w, f1_trap_w, f1_flow_w, br_ill_w;
  logic is_reg, is_branch;

  dec_field_split #(
    .P_WORD_W(WORD_W), .P_OPC_W(OPC_W), .P_RIDX_W(RIDX_W), .P_IMM_W(IMM_W)
  ) u_split (
    .word_i(instr_i), .form_o(form_o), .opc_o(opcode_o),
    .ra_o(reg_a_o), .rb_o(reg_b_o), .imm_o(imm_o)
  );

  dec_op_table #(.P_OPC_W(OPC_W)) u_tab (
    .opc_i(opcode_o), .ext_o(f1_ext_w), .ill_o(f1_ill_w),
    .trap_o(f1_trap_w), .flow_o(f1_flow_w)
  );

  dec_branch_check #(.P_BR_W(BR_OPC_W)) u_br (
    .br_op_i(opcode_o[BR_OPC_W-1:0]), .ill_o(br_ill_w)
  );

  assign is_reg    = (form_o == FORM_REG);
  assign is_branch = (form_o == FORM_BRANCH);

  always_comb begin
    illegal_o = (is_reg & f1_ill_w) | (is_branch & br_ill_w);
    trap_o    = is_reg & f1_trap_w;
    flow_o    = is_branch | (is_reg & f1_flow_w);
    len_o     = 3'd2;
    if (is_reg && !f1_ill_w) len_o = len_bytes(f1_ext_w);
  end

  always_comb begin
    if (illegal_o)
      AST_ILL_SHORT: assert (len_o == 3'd2) else $error("illegal not 2 bytes"); // R10
    AST_LEN_SET: assert (len_o == 3'd2 || len_o == 3'd4 || len_o == 3'd6) else $error("bad length"); // R7
    if (trap_o)
      AST_TRAP_FORM: assert (form_o == FORM_REG && !illegal_o) else $error("trap form"); // R11
    if (instr_i[WORD_W-1] && instr_i[WORD_W-2])
      AST_BRANCH_FLOW: assert (flow_o && form_o == FORM_BRANCH) else $error("branch flow"); // R12
    if (!instr_i[WORD_W-1])
      AST_REG_FORM: assert (form_o == FORM_REG) else $error("register form"); // R1
  end
endmodule

// File: tb/sim_instr_form_decoder.sv
module sim_instr_form_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] instr;
  logic [1:0]  form;
  logic [7:0]  opc;
  logic [3:0]  ra, rb;
  logic [7:0]  imm;
  logic [2:0]  len;
  logic        ill, trap, flow;

  instr_form_decoder u0 (
    .instr_i(instr), .form_o(form), .opcode_o(opc), .reg_a_o(ra),
    .reg_b_o(rb), .imm_o(imm), .len_o(len), .illegal_o(ill),
    .trap_o(trap), .flow_o(flow)
  );

  typedef struct packed {
    logic [15:0] w;
    logic [1:0]  form;
    logic [7:0]  opc;
    logic [3:0]  ra, rb;
    logic [7:0]  imm;
    logic [2:0]  len;
    logic        ill, trap, flow;
    logic        six, four;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit driving_done = 0, summary_done = 0;

  function automatic exp_t model(input logic [15:0] w);
    exp_t e;
    e = '0;
    e.w = w;
    if (!w[15]) begin
      e.form = 2'd1; e.opc = w[15:8]; e.ra = w[7:4]; e.rb = w[3:0];
      case (w[15:8])
        8'h01, 8'h03, 8'h08, 8'h09, 8'h1A, 8'h1B, 8'h1D, 8'h1F,
        8'h20, 8'h22, 8'h24, 8'h30: e.six = 1;
        8'h0C, 8'h0D, 8'h36, 8'h37, 8'h38, 8'h39: e.four = 1;
        default: ;
      endcase
      e.ill  = (w[15:8] == 0) || (w[15:8] == 8'h16) || (w[15:8] == 8'h17) ||
               (w[15:8] == 8'h18) || (w[15:8] >= 8'h3A);
      e.trap = (w[15:8] == 8'h35);
      case (w[15:8])
        8'h03, 8'h04, 8'h19, 8'h1A, 8'h25, 8'h30: e.flow = 1;
        default: e.flow = 0;
      endcase
    end else if (!w[14]) begin
      e.form = 2'd2; e.opc = {6'd0, w[13:12]}; e.ra = w[11:8]; e.imm = w[7:0];
    end else begin
      e.form = 2'd3; e.opc = {4'd0, w[13:10]};
      e.ill = (w[13:10] >= 4'd10); e.flow = 1;
    end
    e.len = e.ill ? 3'd2 : (e.six ? 3'd6 : (e.four ? 3'd4 : 3'd2));
    return e;
  endfunction

  task automatic drive(input logic [15:0] w);
    @(posedge clk);
    instr = w;
    q.push_back(model(w));
  endtask

  task automatic chk(input string tag, input int act, input int exp, input logic [15:0] w);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s word=%h actual=%0h expected=%0h", tag, w, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      string ft, lt;
      e = q.pop_front();
      ft = (e.form == 1) ? "R2" : ((e.form == 2) ? "R3" : "R4");
      lt = e.ill ? "R10" : (e.six ? "R5" : (e.four ? "R6" : "R7"));
      chk("R1 form", form, e.form, e.w);
      chk({ft, " opcode"}, opc, e.opc, e.w);
      chk({ft, " reg_a"}, ra, e.ra, e.w);
      chk({ft, " reg_b"}, rb, e.rb, e.w);
      chk({ft, " imm"}, imm, e.imm, e.w);
      chk({lt, " len"}, len, e.len, e.w);
      chk((e.form == 3) ? "R9 illegal" : "R8 illegal", ill, e.ill, e.w);
      chk("R11 trap", trap, e.trap, e.w);
      chk("R12 flow", flow, e.flow, e.w);
    end
  end

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    instr = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle word after reset: form 1, opcode 0x00, illegal (R8, R10)
    drive(16'h0000);
    // R5 six-byte opcodes, R6 four-byte, R7 plain, R11 trap
    drive(16'h0112); drive(16'h30AB); drive(16'h0C34); drive(16'h3956);
    drive(16'h0578); drive(16'h35FF); drive(16'h0F00);
    // R8 boundaries
    drive(16'h1600); drive(16'h1800); drive(16'h3A00); drive(16'h7FFF);
    drive(16'h1500); drive(16'h1900);
    // R3 short form, R9 branch boundaries, R12 flow
    drive(16'h8AFE); drive(16'hB3C1); drive(16'hE400); drive(16'hE800);
    drive(16'hFFFF); drive(16'hC000);
    // Full sweep of every word
    for (int i = 0; i < 65536; i++) drive(16'(i));
    driving_done = 1;
    @(posedge clk);
    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired before completion");
    finish_run();
  end
endmodule